// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the slave side of a byte-addressable serial memory holding 8192 bytes. The SPI pins are sampled on the system clock and must already be synchronous to it. Each SCK half period lasts at least three system clocks. While chip select is low, the block shifts SI in on each rising SCK edge, most significant bit first. The first eight bits form an instruction byte. Depending on that byte, the block streams array data or the status byte out on SO, updates the write enable flag or the protection bits, or passes write data on to an external page write buffer.

The array is a synchronous RAM inside the block. Reads come straight from it. Writes never touch it directly: each incoming data byte goes to the page buffer as a one-cycle valid strobe carrying its address. A start strobe opens the burst and a commit strobe closes it. The buffer reports its programming cycle on `wrBusy` and later stores the bytes through the RAM write port. A hold input freezes the serial transfer without ending it.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `soOe` is low and no strobe is raised. An RDSR issued first returns 0x00.
- R2: Instruction codes are READ 0x03, WRITE 0x02, WREN 0x06, WRDI 0x04, RDSR 0x05 and WRSR 0x01. All bytes travel MSB first, and SI is taken on each rising SCK edge while chip select is low.
- R3: READ is followed by a 16-bit address whose top three bits are ignored. Data leaves on SO MSB first. Each bit changes on falling SCK, and the first bit appears at the falling edge after the last address bit.
- R4: During READ the address advances after every byte, and it wraps from 0x1FFF to 0x0000 with no limit.
- R5: `soOe` is low whenever chip select is high or hold is low. Raising chip select ends a read at any bit.
- R6: WREN sets WEL only when chip select rises directly after exactly eight bits. A WRITE clocked in the same frame after WREN produces no strobe.
- R7: WRDI clears WEL when chip select rises directly after exactly eight bits.
- R8: The status byte holds WIP in bit 0 (it follows `wrBusy`), WEL in bit 1, BP0 in bit 2, BP1 in bit 3 and WPEN in bit 7, with the other bits zero. RDSR keeps working while `wrBusy` is high, and WEL clears when `wrBusy` falls.
- R9: WRITE with WEL set raises `wrStart` with the start address on `wrAddr`. Each later full byte raises `wrValid` with its data and address. The address wraps within a 32-byte page (the low five bits roll over).
- R10: `wrCommit` pulses for one cycle only if chip select rises on a byte boundary after at least one full data byte of a WRITE.
- R11: WRSR with WEL set copies data bits 7, 3 and 2 into WPEN, BP1 and BP0 when chip select rises after exactly one data byte, and clears WEL. Without WEL, WRSR has no effect.
- R12: While `wrBusy` is high, READ, WRITE, WREN and WRSR are ignored for the rest of the frame, and READ leaves `soOe` low.
- R13: While hold is low, SCK edges are ignored and all shift state is kept. After hold is released, the transfer continues at the same bit.
- R14: An unknown instruction byte makes the block ignore the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| csN | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Hold, active low |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for so |
| wrBusy | input | 1 | Page buffer programming cycle in progress |
| wrStart | output | 1 | Write burst start strobe |
| wrValid | output | 1 | Write data byte valid strobe |
| wrAddr | output | 13 | Address of the start or of the data byte |
| wrData | output | 8 | Write data byte |
| wrCommit | output | 1 | Write burst commit strobe |
| memWrEn | input | 1 | RAM write enable from the page buffer |
| memWrAddr | input | 13 | RAM write address |
| memWrData | input | 8 | RAM write data |

## Verification
The hardest cases to reach are the frame-boundary rules. WEL must change only when chip select rises exactly on an opcode boundary. A commit must come only from a byte-aligned rise after real data. The stimulus builds frames bit by bit: it appends a ninth bit after WREN, clocks a WRITE into the WREN frame, and drops a WRITE partway through a byte. The read-back goes through RDSR and the strobe counters. Hold is asserted halfway through a read byte with SCK still toggling, and the byte is then finished to show that no bit was lost or repeated.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int ADDR_W = 13;
  localparam int PAGE_W = 5;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef enum logic [3:0] {
    PH_OPC, PH_ADDRH, PH_ADDRL, PH_RDDATA, PH_WRDATA,
    PH_RDSR, PH_WRSR, PH_SRDONE, PH_EN, PH_DIS, PH_IGN
  } phase_t;

  typedef struct packed {
    logic       shift;
    logic       addrHi;
    logic       addrLo;
    logic       incSeq;
    logic       wrByte;
    logic       wrStart;
    logic       outLoad;
    logic       clrOut;
    logic       useStatus;
    logic [2:0] outIdx;
  } dpCtl_t;

endpackage

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       holdN,
  input  logic       wrBusy,
  input  logic [7:0] rxByte,
  output dpCtl_t     ctl,
  output logic [7:0] status,
  output logic       soOe,
  output logic       wrCommit
);

  logic       sckQ, csQ, busyQ;
  phase_t     phase;
  logic [2:0] bitCnt;
  logic       wel, wpen, isWrite, gotByte;
  logic [1:0] bp;
  logic [7:0] srNew;

  logic sckRise, sckFall, csRise, csFall, byteDone, outPhase;

  assign sckRise  = sck & ~sckQ & ~csN & holdN;
  assign sckFall  = ~sck & sckQ & ~csN & holdN;
  assign csRise   = csN & ~csQ;
  assign csFall   = ~csN & csQ;
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign outPhase = (phase == PH_RDDATA) || (phase == PH_RDSR);

  assign status = {wpen, 3'b000, bp, wel, wrBusy};
  assign soOe   = ~csN & holdN & outPhase;

  always_comb begin
    ctl           = '0;
    ctl.shift     = sckRise;
    ctl.addrHi    = byteDone && (phase == PH_ADDRH);
    ctl.addrLo    = byteDone && (phase == PH_ADDRL);
    ctl.incSeq    = byteDone && (phase == PH_RDDATA);
    ctl.wrByte    = byteDone && (phase == PH_WRDATA);
    ctl.wrStart   = byteDone && (phase == PH_ADDRL) && isWrite;
    ctl.outLoad   = sckFall && outPhase;
    ctl.clrOut    = csFall;
    ctl.useStatus = (phase == PH_RDSR);
    ctl.outIdx    = 3'd7 - bitCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ     <= 1'b0;
      csQ      <= 1'b1;
      busyQ    <= 1'b0;
      phase    <= PH_OPC;
      bitCnt   <= '0;
      wel      <= 1'b0;
      wpen     <= 1'b0;
      bp       <= '0;
      isWrite  <= 1'b0;
      gotByte  <= 1'b0;
      srNew    <= '0;
      wrCommit <= 1'b0;
    end else begin
      sckQ     <= sck;
      csQ      <= csN;
      busyQ    <= wrBusy;
      wrCommit <= 1'b0;
      if (busyQ && !wrBusy) wel <= 1'b0;
      if (csN) begin
        if (csRise && bitCnt == 3'd0) begin
          unique case (phase)
            PH_EN:     wel <= 1'b1;
            PH_DIS:    wel <= 1'b0;
            PH_WRDATA: wrCommit <= gotByte;
            PH_SRDONE: begin
              wpen <= srNew[7];
              bp   <= srNew[3:2];
              wel  <= 1'b0;
            end
            default: ;
          endcase
        end
        phase   <= PH_OPC;
        bitCnt  <= '0;
        gotByte <= 1'b0;
      end else if (sckRise) begin
        bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          unique case (phase)
            PH_OPC: begin
              isWrite <= 1'b0;
              unique case (rxByte)
                OP_READ:  phase <= wrBusy ? PH_IGN : PH_ADDRH;
                OP_WRITE: begin
                  phase   <= (wel && !wrBusy) ? PH_ADDRH : PH_IGN;
                  isWrite <= 1'b1;
                end
                OP_WREN:  phase <= wrBusy ? PH_IGN : PH_EN;
                OP_WRDI:  phase <= PH_DIS;
                OP_RDSR:  phase <= PH_RDSR;
                OP_WRSR:  phase <= (wel && !wrBusy) ? PH_WRSR : PH_IGN;
                default:  phase <= PH_IGN;
              endcase
            end
            PH_ADDRH:  phase <= PH_ADDRL;
            PH_ADDRL:  phase <= isWrite ? PH_WRDATA : PH_RDDATA;
            PH_WRDATA: gotByte <= 1'b1;
            PH_WRSR: begin
              srNew <= rxByte;
              phase <= PH_SRDONE;
            end
            PH_EN, PH_DIS, PH_SRDONE: phase <= PH_IGN;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_dp.sv
module spi_mem_dp
  import spi_mem_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          si,
  input  dpCtl_t        ctl,
  input  logic [7:0]    status,
  input  logic          memWrEn,
  input  logic [AW-1:0] memWrAddr,
  input  logic [7:0]    memWrData,
  output logic [7:0]    rxByte,
  output logic          so,
  output logic          wrStart,
  output logic          wrValid,
  output logic [AW-1:0] wrAddr,
  output logic [7:0]    wrData
);

  localparam int DEPTH = 1 << AW;
  localparam int HI_W  = AW - 8;

  logic [7:0]    shiftIn;
  logic [AW-1:0] addr;
  logic [7:0]    ramQ;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    outByte;

  assign rxByte  = {shiftIn[6:0], si};
  assign outByte = ctl.useStatus ? status : ramQ;

  always_ff @(posedge clk) begin
    if (memWrEn) mem[memWrAddr] <= memWrData;
    ramQ <= mem[addr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
      addr    <= '0;
      so      <= 1'b0;
      wrStart <= 1'b0;
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrStart <= ctl.wrStart;
      wrValid <= ctl.wrByte;
      if (ctl.shift) shiftIn <= rxByte;
      if (ctl.addrHi) addr[AW-1:8] <= rxByte[HI_W-1:0];
      if (ctl.addrLo) addr[7:0] <= rxByte;
      if (ctl.incSeq) addr <= addr + 1'b1;
      if (ctl.wrByte) addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
      if (ctl.wrStart) wrAddr <= {addr[AW-1:8], rxByte};
      if (ctl.wrByte) begin
        wrAddr <= addr;
        wrData <= rxByte;
      end
      if (ctl.clrOut) so <= 1'b0;
      else if (ctl.outLoad) so <= outByte[ctl.outIdx];
    end
  end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sck,
  input  logic          csN,
  input  logic          si,
  input  logic          holdN,
  output logic          so,
  output logic          soOe,
  input  logic          wrBusy,
  output logic          wrStart,
  output logic          wrValid,
  output logic [AW-1:0] wrAddr,
  output logic [7:0]    wrData,
  output logic          wrCommit,
  input  logic          memWrEn,
  input  logic [AW-1:0] memWrAddr,
  input  logic [7:0]    memWrData
);

  dpCtl_t     ctl;
  logic [7:0] status;
  logic [7:0] rxByte;

  spi_mem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .holdN(holdN),
    .wrBusy(wrBusy), .rxByte(rxByte), .ctl(ctl), .status(status),
    .soOe(soOe), .wrCommit(wrCommit)
  );

  spi_mem_dp #(.AW(AW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .si(si), .ctl(ctl), .status(status),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .rxByte(rxByte), .so(so), .wrStart(wrStart), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic holdN,
  input logic soOe,
  input logic wrStart,
  input logic wrValid,
  input logic wrCommit
);

  a_r5_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !holdN) |-> !soOe);

  a_r9_start_not_valid: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> !wrValid);

  a_r10_commit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  a_r10_commit_on_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> $past(csN));

  a_r13_hold_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !$past(holdN) |-> (!wrValid && !wrStart));

endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .holdN(holdN), .soOe(soOe),
  .wrStart(wrStart), .wrValid(wrValid), .wrCommit(wrCommit)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;

  localparam int CLK_PERIOD = 10;

  localparam int P_OPC = 0, P_AH = 1, P_AL = 2, P_RD = 3, P_WR = 4,
                 P_SR = 5, P_WS = 6, P_SD = 7, P_EN = 8, P_DIS = 9, P_IGN = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic sck = 1'b0, csN = 1'b1, si = 1'b0, holdN = 1'b1, wrBusy = 1'b0;
  logic memWrEn = 1'b0;
  logic [12:0] memWrAddr = '0;
  logic [7:0] memWrData = '0;
  logic so, soOe, wrStart, wrValid, wrCommit;
  logic [12:0] wrAddr;
  logic [7:0] wrData;

  int compared = 0, mismatched = 0;
  int startCnt = 0, validCnt = 0, commitCnt = 0;
  logic [12:0] capA[$];
  logic [7:0] capD[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_slave u_dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .holdN(holdN),
    .so(so), .soOe(soOe), .wrBusy(wrBusy), .wrStart(wrStart),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrCommit(wrCommit),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  // behavioural reference model
  int mPh;
  logic [2:0] mBit;
  logic [7:0] mSh, mSr, mRamQ;
  logic [12:0] mAddr;
  logic mWel, mWpen, mWrite, mGot, mSo;
  logic [1:0] mBp;
  logic pSck, pCs, pBusy;
  logic eStart, eValid, eCommit;
  logic [12:0] eAddr;
  logic [7:0] eData;
  logic [7:0] mMem [8192];

  always @(posedge clk) begin : model
    logic rise, fall, csR, csF;
    logic [7:0] rx, st, ob;
    if (!rstN) begin
      mPh = P_OPC; mBit = 0; mSh = 0; mSr = 0; mAddr = 0; mWel = 0; mWpen = 0;
      mBp = 0; mWrite = 0; mGot = 0; mSo = 0; pSck = 0; pCs = 1; pBusy = 0;
      eStart = 0; eValid = 0; eCommit = 0; eAddr = 0; eData = 0;
    end else begin
      rise = sck && !pSck && !csN && holdN;
      fall = !sck && pSck && !csN && holdN;
      csR = csN && !pCs;
      csF = !csN && pCs;
      rx = {mSh[6:0], si};
      st = {mWpen, 3'b000, mBp, mWel, wrBusy};
      eStart = 0; eValid = 0; eCommit = 0;
      ob = (mPh == P_SR) ? st : mRamQ;
      if (csF) mSo = 0;
      else if (fall && (mPh == P_RD || mPh == P_SR)) mSo = ob[7 - mBit];
      mRamQ = mMem[mAddr];
      if (memWrEn) mMem[memWrAddr] = memWrData;
      if (pBusy && !wrBusy) mWel = 0;
      if (csN) begin
        if (csR && mBit == 0) begin
          if (mPh == P_EN) mWel = 1;
          if (mPh == P_DIS) mWel = 0;
          if (mPh == P_WR && mGot) eCommit = 1;
          if (mPh == P_SD) begin mWpen = mSr[7]; mBp = mSr[3:2]; mWel = 0; end
        end
        mPh = P_OPC; mBit = 0; mGot = 0;
      end else if (rise) begin
        mSh = rx;
        if (mBit == 7) begin
          case (mPh)
            P_OPC: begin
              mWrite = (rx == 8'h02);
              case (rx)
                8'h03: mPh = wrBusy ? P_IGN : P_AH;
                8'h02: mPh = (mWel && !wrBusy) ? P_AH : P_IGN;
                8'h06: mPh = wrBusy ? P_IGN : P_EN;
                8'h04: mPh = P_DIS;
                8'h05: mPh = P_SR;
                8'h01: mPh = (mWel && !wrBusy) ? P_WS : P_IGN;
                default: mPh = P_IGN;
              endcase
            end
            P_AH: begin mAddr[12:8] = rx[4:0]; mPh = P_AL; end
            P_AL: begin
              mAddr[7:0] = rx;
              if (mWrite) begin eStart = 1; eAddr = mAddr; mPh = P_WR; end
              else mPh = P_RD;
            end
            P_RD: mAddr = mAddr + 13'd1;
            P_WR: begin
              eValid = 1; eAddr = mAddr; eData = rx; mGot = 1;
              mAddr[4:0] = mAddr[4:0] + 5'd1;
            end
            P_WS: begin mSr = rx; mPh = P_SD; end
            P_EN, P_DIS, P_SD: mPh = P_IGN;
            default: ;
          endcase
        end
        mBit = mBit + 3'd1;
      end
      pSck = sck; pCs = csN; pBusy = wrBusy;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin : cmp
    logic oeExp;
    if (rstN) begin
      oeExp = !csN && holdN && (mPh == P_RD || mPh == P_SR);
      compared++;
      if (soOe !== oeExp) begin
        mismatched++; $display("FAIL R5 soOe actual=%b expected=%b", soOe, oeExp);
      end else if (oeExp && so !== mSo) begin
        mismatched++; $display("FAIL R3 so actual=%b expected=%b", so, mSo);
      end else if (wrStart !== eStart || wrValid !== eValid) begin
        mismatched++; $display("FAIL R9 start/valid actual=%b%b expected=%b%b",
                               wrStart, wrValid, eStart, eValid);
      end else if ((eStart || eValid) && wrAddr !== eAddr) begin
        mismatched++; $display("FAIL R9 wrAddr actual=%h expected=%h", wrAddr, eAddr);
      end else if (eValid && wrData !== eData) begin
        mismatched++; $display("FAIL R9 wrData actual=%h expected=%h", wrData, eData);
      end else if (wrCommit !== eCommit) begin
        mismatched++; $display("FAIL R10 wrCommit actual=%b expected=%b", wrCommit, eCommit);
      end
      if (wrStart) startCnt++;
      if (wrValid) begin validCnt++; capA.push_back(wrAddr); capD.push_back(wrData); end
      if (wrCommit) commitCnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic o);
    si = b; sck = 1'b0; tick(3);
    sck = 1'b1; tick(3);
    o = so;
  endtask

  task automatic sendByte(input logic [7:0] v);
    logic o;
    for (int i = 7; i >= 0; i--) bitx(v[i], o);
  endtask

  task automatic getByte(output logic [7:0] v);
    logic o;
    for (int i = 7; i >= 0; i--) begin bitx(1'b0, o); v[i] = o; end
  endtask

  task automatic csLow();
    sck = 1'b0; csN = 1'b0; tick(2);
  endtask

  task automatic csHigh();
    sck = 1'b0; tick(2); csN = 1'b1; tick(3);
  endtask

  task automatic cmd(input logic [7:0] op);
    csLow(); sendByte(op); csHigh();
  endtask

  task automatic rdsr(output logic [7:0] v);
    csLow(); sendByte(8'h05); getByte(v); csHigh();
  endtask

  task automatic preload(input logic [12:0] a, input logic [7:0] d);
    memWrEn = 1'b1; memWrAddr = a; memWrData = d; tick(1);
    memWrEn = 1'b0; tick(1);
  endtask

  task automatic readCheck(input logic [15:0] a, input int n, input string tag);
    logic [7:0] v;
    logic [12:0] p;
    csLow(); sendByte(8'h03); sendByte(a[15:8]); sendByte(a[7:0]);
    p = a[12:0];
    for (int k = 0; k < n; k++) begin
      getByte(v);
      check(tag, {8'h00, v}, {8'h00, mMem[p]});
      p = p + 13'd1;
    end
    csHigh();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    logic o;
    int s0, c0;
    tick(4); rstN = 1'b1; tick(2);
    check("R1 soOe after reset", {15'h0, soOe}, 16'h0);
    check("R1 strobes after reset", {13'h0, wrStart, wrValid, wrCommit}, 16'h0);
    rdsr(v); check("R1 status after reset", {8'h0, v}, 16'h0000);

    for (int i = 0; i < 8; i++) preload(13'h0010 + 13'(i), 8'(8'h3C + 17 * i));
    preload(13'h1FFE, 8'hA5); preload(13'h1FFF, 8'h5A);
    preload(13'h0000, 8'hC3); preload(13'h0001, 8'h96);

    readCheck(16'hE010, 3, "R3 read with ignored top bits");
    readCheck(16'h0013, 4, "R2 read msb first");
    readCheck(16'h1FFE, 4, "R4 read wraps 1FFF to 0000");

    // R5: chip select rise mid byte ends the read
    csLow(); sendByte(8'h03); sendByte(8'h00); sendByte(8'h10);
    for (int i = 0; i < 3; i++) bitx(1'b0, o);
    csHigh();
    check("R5 soOe after cs rise", {15'h0, soOe}, 16'h0);

    // R14: unknown opcode then WREN bits in same frame
    csLow(); sendByte(8'hAA); sendByte(8'h06); csHigh();
    rdsr(v); check("R14 unknown opcode ignored", {8'h0, v}, 16'h0000);

    // R6: WREN with a ninth bit does not set WEL
    csLow(); sendByte(8'h06); bitx(1'b0, o); csHigh();
    rdsr(v); check("R6 WREN plus extra bit", {8'h0, v}, 16'h0000);
    cmd(8'h06);
    rdsr(v); check("R6 WREN sets WEL", {8'h0, v}, 16'h0002);
    cmd(8'h04);
    rdsr(v); check("R7 WRDI clears WEL", {8'h0, v}, 16'h0000);

    // R6: WRITE in same frame as WREN
    s0 = startCnt;
    csLow(); sendByte(8'h06); sendByte(8'h02); sendByte(8'h00); sendByte(8'h40);
    sendByte(8'h11); csHigh();
    check("R6 WRITE in WREN frame no start", 16'(startCnt - s0), 16'h0);

    // R9/R10: page write wrapping
    cmd(8'h06);
    s0 = startCnt; c0 = commitCnt; capA.delete(); capD.delete();
    csLow(); sendByte(8'h02); sendByte(8'h00); sendByte(8'h3E);
    sendByte(8'hA1); sendByte(8'hB2); sendByte(8'hC3); csHigh();
    check("R9 one start", 16'(startCnt - s0), 16'h1);
    check("R9 byte count", 16'(capA.size()), 16'h3);
    if (capA.size() == 3) begin
      check("R9 addr 0", {3'b0, capA[0]}, 16'h003E);
      check("R9 addr 1", {3'b0, capA[1]}, 16'h003F);
      check("R9 page wrap addr", {3'b0, capA[2]}, 16'h0020);
      check("R9 data 2", {8'h0, capD[2]}, 16'h00C3);
    end
    check("R10 commit on boundary", 16'(commitCnt - c0), 16'h1);

    // R10: partial byte -> no commit
    cmd(8'h06);
    c0 = commitCnt;
    csLow(); sendByte(8'h02); sendByte(8'h00); sendByte(8'h50); sendByte(8'h77);
    for (int i = 0; i < 4; i++) bitx(1'b1, o);
    csHigh();
    check("R10 no commit mid byte", 16'(commitCnt - c0), 16'h0);
    c0 = commitCnt;
    csLow(); sendByte(8'h02); sendByte(8'h00); sendByte(8'h50); csHigh();
    check("R10 no commit without data", 16'(commitCnt - c0), 16'h0);

    // R8/R12: busy window
    wrBusy = 1'b1; tick(2);
    rdsr(v); check("R8 RDSR during busy", {8'h0, v}, 16'h0003);
    csLow(); sendByte(8'h03); sendByte(8'h00); sendByte(8'h10);
    bitx(1'b0, o);
    check("R12 read refused while busy", {15'h0, soOe}, 16'h0);
    csHigh();
    s0 = startCnt;
    csLow(); sendByte(8'h02); sendByte(8'h00); sendByte(8'h10); sendByte(8'h22); csHigh();
    check("R12 write refused while busy", 16'(startCnt - s0), 16'h0);
    wrBusy = 1'b0; tick(2);
    rdsr(v); check("R8 WEL cleared at busy end", {8'h0, v}, 16'h0000);

    // R11: status write
    csLow(); sendByte(8'h01); sendByte(8'hFF); csHigh();
    rdsr(v); check("R11 WRSR without WEL", {8'h0, v}, 16'h0000);
    cmd(8'h06);
    csLow(); sendByte(8'h01); sendByte(8'hFF); csHigh();
    rdsr(v); check("R11 WRSR sets bits 7,3,2", {8'h0, v}, 16'h008C);
    cmd(8'h06);
    rdsr(v); check("R8 layout with WEL", {8'h0, v}, 16'h008E);
    cmd(8'h04);

    // R13: hold mid byte
    csLow(); sendByte(8'h03); sendByte(8'h00); sendByte(8'h12);
    for (int i = 7; i >= 0; i--) begin
      if (i == 3) begin
        sck = 1'b0; tick(2);
        holdN = 1'b0; tick(2);
        check("R13 soOe low in hold", {15'h0, soOe}, 16'h0);
        for (int k = 0; k < 3; k++) begin
          si = 1'b1; sck = 1'b1; tick(3); sck = 1'b0; tick(3);
        end
        holdN = 1'b1; tick(2);
      end
      bitx(1'b0, o); v[i] = o;
    end
    check("R13 byte intact across hold", {8'h0, v}, {8'h0, mMem[13'h0012]});
    getByte(v);
    check("R13 next byte after hold", {8'h0, v}, {8'h0, mMem[13'h0013]});
    csHigh();

    tick(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule